// File: doc/BRIEF.md
# Alignment Interrupt State Updater

This block sits at the point where a core accepts an alignment exception. On the cycle it is told that the interrupt is taken, it loads the architected interrupt-processing registers in a single clock edge. It saves the faulting instruction address and the old machine state, and builds the new machine state. It records the data byte that caused the fault and classifies the instruction in a syndrome word. It also forms the fetch address of the handler from the vector prefix and a fixed offset.

A one-cycle redirect strobe follows every accepted exception. The fetch unit uses it together with the redirect address. Registers that the exception does not touch keep their values from one exception to the next. Returning from the interrupt and every other interrupt class are handled elsewhere.

Top module: `align_intr_update`

## Requirements
- R1: When `take_i` is high at a rising edge, `srr0_o` holds `instr_ea_i` from the following cycle on.
- R2: When `take_i` is high at a rising edge, `srr1_o` holds the complete 64-bit `msr_i` sampled at that edge.
- R3: When `take_i` is high at a rising edge, `msr_o` gets bit 63 (computation mode) from `icm_i`. Bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable) are copied from `msr_i`. Every other bit is 0.
- R4: When `take_i` is high at a rising edge, `dear_o` holds `fault_addr_i`.
- R5: When `take_i` is high at a rising edge, `esr_o` is loaded as follows: bit 3 = `is_fp_i`, bit 2 = `is_store_i`, bit 1 = `is_aux_i`, bit 0 = `is_ext_pid_i`, and all other 28 bits are 0.
- R6: When `take_i` is high at a rising edge, `redirect_addr_o` becomes `{vec_prefix_i, 12'h0C0}`, so its low 12 bits are always 0x0C0 after a take.
- R7: `redirect_vld_o` is high in exactly the cycle after each edge where `take_i` was high, and low in every other cycle.
- R8: At an edge where `take_i` is low, `srr0_o`, `srr1_o`, `msr_o`, `dear_o`, `esr_o` and `redirect_addr_o` keep their values, whatever the other inputs do.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | The alignment interrupt is accepted this cycle |
| instr_ea_i | input | 64 | Effective address of the faulting instruction |
| msr_i | input | 64 | Machine state before the interrupt |
| icm_i | input | 1 | Computation mode to use for the interrupt |
| vec_prefix_i | input | 52 | Interrupt vector prefix |
| fault_addr_i | input | 64 | Faulting byte address inside the accessed range and page |
| is_fp_i | input | 1 | The instruction is a floating-point load or store |
| is_store_i | input | 1 | The instruction is store-like (store, zero-line, line invalidate) |
| is_aux_i | input | 1 | The instruction is an auxiliary-unit load or store |
| is_ext_pid_i | input | 1 | The instruction uses the external process ID |
| srr0_o | output | 64 | Save/restore register 0 |
| srr1_o | output | 64 | Save/restore register 1 |
| msr_o | output | 64 | New machine state |
| dear_o | output | 64 | Data exception address register |
| esr_o | output | 32 | Exception syndrome register |
| redirect_addr_o | output | 64 | Handler fetch address |
| redirect_vld_o | output | 1 | One-cycle redirect strobe |

## Verification
The vector table covers several exception patterns:

- An all-ones machine state with computation mode cleared, which shows that only the three preserved enables survive.
- An all-zero machine state with computation mode set, which shows that the mode bit comes from the control input and not from the old state.
- Single-flag and mixed-flag instruction classes, which tell each syndrome bit from its neighbours.
- Different prefixes, which separate the prefix field from the fixed offset.

After every take, the bench scrambles the inputs with the strobe low. This shows that the registers hold and that the redirect strobe lasts one cycle. Back-to-back takes then show that the strobe stays high and the newer values win.

// File: rtl/aiu_pkg.sv
package aiu_pkg;
    localparam int XLEN      = 64;
    localparam int OFF_W     = 12;
    localparam int PFX_W     = XLEN - OFF_W;
    localparam int SYN_W     = 32;
    localparam logic [OFF_W-1:0] VEC_OFFSET = 12'h0C0;

    typedef struct packed {
        logic [XLEN-1:0]  srr0;
        logic [XLEN-1:0]  srr1;
        logic [XLEN-1:0]  msr;
        logic [XLEN-1:0]  dear;
        logic [SYN_W-1:0] esr;
        logic [XLEN-1:0]  redir;
        logic             vld;
    } aiu_state_t;
endpackage

// File: rtl/aiu_msr_gen.sv
module aiu_msr_gen #(
    parameter int W      = 64,
    parameter int CM_POS = 63,
    parameter int CE_POS = 17,
    parameter int ME_POS = 12,
    parameter int DE_POS = 9
) (
    input  logic [W-1:0] cur_i,
    input  logic         icm_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] KEEP_MASK =
        (W'(1) << CE_POS) | (W'(1) << ME_POS) | (W'(1) << DE_POS);

    always_comb begin
        for (int i = 0; i < W; i++) begin
            nxt_o[i] = KEEP_MASK[i] ? cur_i[i] : 1'b0;
        end
        nxt_o[CM_POS] = icm_i;
    end
endmodule

// File: rtl/aiu_esr_gen.sv
module aiu_esr_gen #(
    parameter int W        = 32,
    parameter int FP_POS   = 3,
    parameter int ST_POS   = 2,
    parameter int AUX_POS  = 1,
    parameter int EPID_POS = 0
) (
    input  logic         fp_i,
    input  logic         st_i,
    input  logic         aux_i,
    input  logic         epid_i,
    output logic [W-1:0] esr_o
);
    always_comb begin
        esr_o           = '0;
        esr_o[FP_POS]   = fp_i;
        esr_o[ST_POS]   = st_i;
        esr_o[AUX_POS]  = aux_i;
        esr_o[EPID_POS] = epid_i;
    end
endmodule

// File: rtl/align_intr_update.sv
module align_intr_update
    import aiu_pkg::*;
#(
    parameter int CM_POS = 63,
    parameter int CE_POS = 17,
    parameter int ME_POS = 12,
    parameter int DE_POS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [XLEN-1:0]  instr_ea_i,
    input  logic [XLEN-1:0]  msr_i,
    input  logic             icm_i,
    input  logic [PFX_W-1:0] vec_prefix_i,
    input  logic [XLEN-1:0]  fault_addr_i,
    input  logic             is_fp_i,
    input  logic             is_store_i,
    input  logic             is_aux_i,
    input  logic             is_ext_pid_i,
    output logic [XLEN-1:0]  srr0_o,
    output logic [XLEN-1:0]  srr1_o,
    output logic [XLEN-1:0]  msr_o,
    output logic [XLEN-1:0]  dear_o,
    output logic [SYN_W-1:0] esr_o,
    output logic [XLEN-1:0]  redirect_addr_o,
    output logic             redirect_vld_o
);
    aiu_state_t state_d, state_q;
    logic [XLEN-1:0]  new_msr;
    logic [SYN_W-1:0] new_esr;

    aiu_msr_gen #(
        .W(XLEN), .CM_POS(CM_POS), .CE_POS(CE_POS),
        .ME_POS(ME_POS), .DE_POS(DE_POS)
    ) u_msr_gen (
        .cur_i (msr_i),
        .icm_i (icm_i),
        .nxt_o (new_msr)
    );

    aiu_esr_gen #(.W(SYN_W)) u_esr_gen (
        .fp_i   (is_fp_i),
        .st_i   (is_store_i),
        .aux_i  (is_aux_i),
        .epid_i (is_ext_pid_i),
        .esr_o  (new_esr)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = take_i;
        if (take_i) begin
            state_d.srr0  = instr_ea_i;
            state_d.srr1  = msr_i;
            state_d.msr   = new_msr;
            state_d.dear  = fault_addr_i;
            state_d.esr   = new_esr;
            state_d.redir = {vec_prefix_i, VEC_OFFSET};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign srr0_o          = state_q.srr0;
    assign srr1_o          = state_q.srr1;
    assign msr_o           = state_q.msr;
    assign dear_o          = state_q.dear;
    assign esr_o           = state_q.esr;
    assign redirect_addr_o = state_q.redir;
    assign redirect_vld_o  = state_q.vld;

    AST_SRR0_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> srr0_o == $past(instr_ea_i)); // R1
    AST_SRR1_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> srr1_o == $past(msr_i)); // R2
    AST_MSR_ENABLES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (msr_o[CE_POS] == $past(msr_i[CE_POS])) &&
                   (msr_o[ME_POS] == $past(msr_i[ME_POS])) &&
                   (msr_o[DE_POS] == $past(msr_i[DE_POS])) &&
                   (msr_o[CM_POS] == $past(icm_i))); // R3
    AST_MSR_FEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld_o |-> $countones(msr_o) <= 4); // R3
    AST_DEAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> dear_o == $past(fault_addr_i)); // R4
    AST_ESR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld_o |-> esr_o[SYN_W-1:4] == '0); // R5
    AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld_o |-> redirect_addr_o[OFF_W-1:0] == VEC_OFFSET); // R6
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> !redirect_vld_o); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) &&
                    $stable(dear_o) && $stable(esr_o) && $stable(redirect_addr_o)); // R8
endmodule

// File: tb/align_intr_update_tb.sv
module align_intr_update_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        take_i;
    logic [63:0] instr_ea_i, msr_i, fault_addr_i;
    logic        icm_i;
    logic [51:0] vec_prefix_i;
    logic        is_fp_i, is_store_i, is_aux_i, is_ext_pid_i;
    logic [63:0] srr0_o, srr1_o, msr_o, dear_o, redirect_addr_o;
    logic [31:0] esr_o;
    logic        redirect_vld_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    align_intr_update u_dut (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .instr_ea_i(instr_ea_i),
        .msr_i(msr_i), .icm_i(icm_i), .vec_prefix_i(vec_prefix_i),
        .fault_addr_i(fault_addr_i), .is_fp_i(is_fp_i), .is_store_i(is_store_i),
        .is_aux_i(is_aux_i), .is_ext_pid_i(is_ext_pid_i), .srr0_o(srr0_o),
        .srr1_o(srr1_o), .msr_o(msr_o), .dear_o(dear_o), .esr_o(esr_o),
        .redirect_addr_o(redirect_addr_o), .redirect_vld_o(redirect_vld_o)
    );

    localparam int NV = 5;
    localparam logic [63:0] V_EA   [NV] = '{64'h0000_0000_1000_0004, 64'hFFFF_FFFF_FFFF_FFFC,
                                            64'h1234_5678_9ABC_DEF0, 64'h0, 64'h8000_0000_0000_0abc};
    localparam logic [63:0] V_MSR  [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
                                            64'h8000_0000_0002_0000, 64'h0000_0000_0000_1200, 64'h5555_5555_5555_5555};
    localparam logic        V_ICM  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [51:0] V_PFX  [NV] = '{52'h0, 52'hF_FFFF_FFFF_FFFF, 52'h0_0000_1234_5678,
                                            52'hA_5A5A_5A5A_5A5A, 52'h1};
    localparam logic [63:0] V_FA   [NV] = '{64'h0000_0000_1000_0FFF, 64'hDEAD_BEEF_0000_0001,
                                            64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_7000_0000_0008};
    localparam logic [3:0]  V_FLG  [NV] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b1111};

    task automatic chk64(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_msr(input logic [63:0] m, input logic icm);
        logic [63:0] r = 64'h0;
        r[63] = icm; r[17] = m[17]; r[12] = m[12]; r[9] = m[9];
        return r;
    endfunction

    task automatic drive(input int i, input logic tk);
        take_i = tk; instr_ea_i = V_EA[i]; msr_i = V_MSR[i]; icm_i = V_ICM[i];
        vec_prefix_i = V_PFX[i]; fault_addr_i = V_FA[i];
        {is_fp_i, is_store_i, is_aux_i, is_ext_pid_i} = V_FLG[i];
    endtask

    task automatic check_vec(input int i);
        chk64("R1", "srr0", srr0_o, V_EA[i]);
        chk64("R2", "srr1", srr1_o, V_MSR[i]);
        chk64("R3", "msr", msr_o, exp_msr(V_MSR[i], V_ICM[i]));
        chk64("R4", "dear", dear_o, V_FA[i]);
        chk64("R5", "esr", {32'h0, esr_o}, {60'h0, V_FLG[i]});
        chk64("R6", "redirect", redirect_addr_o, {V_PFX[i], 12'h0C0});
        chk64("R7", "strobe high", {63'h0, redirect_vld_o}, 64'h1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 1'b1);
        repeat (3) @(negedge clk);
        // R9: reset holds every output at zero even with take asserted
        chk64("R9", "srr0 reset", srr0_o, 64'h0);
        chk64("R9", "msr reset", msr_o, 64'h0);
        chk64("R9", "esr reset", {32'h0, esr_o}, 64'h0);
        chk64("R9", "redirect reset", redirect_addr_o, 64'h0);
        chk64("R9", "strobe reset", {63'h0, redirect_vld_o}, 64'h0);
        take_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(i, 1'b1);
            @(negedge clk);
            check_vec(i);
            drive((i + 2) % NV, 1'b0);
            @(negedge clk);
            // R8: scrambled inputs without take leave everything in place
            chk64("R8", "srr0 hold", srr0_o, V_EA[i]);
            chk64("R8", "msr hold", msr_o, exp_msr(V_MSR[i], V_ICM[i]));
            chk64("R8", "dear hold", dear_o, V_FA[i]);
            chk64("R8", "esr hold", {32'h0, esr_o}, {60'h0, V_FLG[i]});
            chk64("R8", "redirect hold", redirect_addr_o, {V_PFX[i], 12'h0C0});
            chk64("R7", "strobe one cycle", {63'h0, redirect_vld_o}, 64'h0);
        end

        // R7: back-to-back takes keep the strobe high and the newest values win
        drive(1, 1'b1);
        @(negedge clk);
        check_vec(1);
        drive(3, 1'b1);
        @(negedge clk);
        check_vec(3);
        take_i = 1'b0;
        @(negedge clk);
        chk64("R7", "strobe drops", {63'h0, redirect_vld_o}, 64'h0);
        chk64("R8", "srr1 hold", srr1_o, V_MSR[3]);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule